// File: doc/BRIEF.md
# DMA Socket Descriptor-Chain Sequencer

This block runs one DMA socket. The socket is either the side that fills buffers (producer) or the side that empties them (consumer). The role is chosen when software enables the socket. Buffer descriptors live in a small local descriptor store, which a host reaches through a plain read/write port. Each descriptor is one packed word. It holds a buffer address, a buffer size, a byte count, a single "full" flag, a peer socket number and the index of the next descriptor.

Once enabled, the socket walks its descriptor chain starting at the head index held in a pointer register. Data movement is modelled as `BPC` bytes per cycle. When a buffer is finished, the socket writes the descriptor back and tells its peer socket through an event word that names the descriptor. If there is no peer, it raises an interrupt instead. It waits in a stall state when the next buffer is not ready. It leaves stall when an event written into its event input hands the buffer back. Reaching the chain terminator puts it in the suspend state.

Top module: `dma_socket_seq`

## Requirements
- R1: After reset the socket state is off (code 0), `active_dscr` is 16'hFFFF, `intr_flags` is 0, and `irq` and `evo_valid` are low.
- R2: A register write with `reg_sel`=0 programs the control word: bit 0 is go and bit 1 selects producer (1) or consumer (0). Writing go=1 starts loading from the head index held by `reg_sel`=1 (bits 15:0). If that head is 16'hFFFF the socket goes straight to suspend. Writing go=0 returns the socket to off. State codes are: off 0, load 1, run 2, stall 3, done 4, suspend 5.
- R3: A producer that loads a descriptor whose full flag is 0 enters run with its count restarted at 0. It adds `BPC` bytes per cycle, so it spends max(1, ceil(size/BPC)) cycles in run. It then writes the descriptor back with count = size and full = 1.
- R4: A consumer that loads a descriptor whose full flag is 1 drains `BPC` bytes per cycle from its count, so it spends max(1, ceil(count/BPC)) cycles in run. It then writes the descriptor back with count = 0 and full = 0.
- R5: When a buffer finishes and the peer field is not all ones, `evo_valid` pulses for exactly one cycle. `evo_sock` carries the peer number. `evo_data` carries the descriptor index in bits 15:0, the event type in bit 16 (1 = produce, sent by a producer; 0 = consume, sent by a consumer) and zero in all other bits.
- R6: When the peer field is all ones, no event is sent. Instead, interrupt bit 0 (producer) or bit 1 (consumer) is set, but only if the same bit of the interrupt mask (`reg_sel`=3) is 1.
- R7: After a buffer finishes, the socket loads the descriptor named by the next field. If that buffer is not ready, it enters stall, and interrupt bit 2 is set when mask bit 2 is 1. "Not ready" means full = 1 for a producer and full = 0 for a consumer.
- R8: In stall, an event write only takes effect when `ev_data[15:0]` equals the active index and `ev_data[16]` is the awaited type (consume = 0 for a producer, produce = 1 for a consumer). Such an event returns the socket to run and updates the held descriptor from the event alone. A producer gets count 0 and full 0; a consumer gets full 1 and count = size. Any other event leaves the socket in stall.
- R9: A next field of 16'hFFFF puts the socket in suspend with `active_dscr` = 16'hFFFF. Interrupt bit 3 is set when mask bit 3 is 1.
- R10: Interrupt bits are sticky. Writing 1s with `reg_sel`=2 clears the matching bits. `irq` is the OR of all four bits.
- R11: The descriptor word is packed from MSB to LSB as: address (`ADDR_W` bits), size (16), count (16), full (1), peer (`SOCK_W`), next (16). `mem_rdata` shows the entry at `mem_addr` in the same cycle, and a host write lands at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 control, 1 head pointer, 2 interrupt clear, 3 interrupt mask |
| reg_wdata | input | 32 | Register write data |
| ev_we | input | 1 | Incoming event strobe |
| ev_data | input | 32 | Incoming event word (index, type) |
| mem_we | input | 1 | Host descriptor write |
| mem_addr | input | $clog2(DEPTH) | Host descriptor index |
| mem_wdata | input | ADDR_W+SOCK_W+49 | Host descriptor write word |
| mem_rdata | output | ADDR_W+SOCK_W+49 | Descriptor word at `mem_addr` |
| sock_state | output | 3 | Socket state code |
| sock_producer | output | 1 | 1 when acting as producer |
| active_dscr | output | 16 | Active descriptor index, 16'hFFFF if none |
| intr_flags | output | 4 | Sticky interrupt bits |
| irq | output | 1 | OR of interrupt bits |
| evo_valid | output | 1 | Outgoing event pulse |
| evo_sock | output | SOCK_W | Outgoing event target socket |
| evo_data | output | 32 | Outgoing event word |

## Verification
The bench builds the block with DEPTH=8, ADDR_W=16, SOCK_W=4 and BPC=4. These small values make the descriptor word 69 bits wide, which the bench can pack in its own code. With BPC=4, every size and count from 0 to 12 can be swept in both roles. That sweep covers the empty-buffer case, exact multiples of the step and every partial last step. Two-entry chains with peers bring stall entry, rejected events, event-driven resumption and chain termination into reach.

// File: rtl/dma_sock_pkg.sv
package dma_sock_pkg;
   typedef enum logic [2:0] {
      SK_OFF   = 3'd0,
      SK_LOAD  = 3'd1,
      SK_RUN   = 3'd2,
      SK_STALL = 3'd3,
      SK_DONE  = 3'd4,
      SK_SUSP  = 3'd5
   } sk_state_e;

   localparam int unsigned IRQ_PROD  = 0;
   localparam int unsigned IRQ_CONS  = 1;
   localparam int unsigned IRQ_STALL = 2;
   localparam int unsigned IRQ_SUSP  = 3;
   localparam int unsigned IRQ_NB    = 4;

   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_PTR  = 2'd1;
   localparam logic [1:0] SEL_INTR = 2'd2;
   localparam logic [1:0] SEL_MASK = 2'd3;

   localparam logic [15:0] CHAIN_END = 16'hFFFF;
endpackage

// File: rtl/dma_sock_dscr_mem.sv
module dma_sock_dscr_mem #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned DW    = 89,
   localparam int unsigned IW   = $clog2(DEPTH)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          h_we,
   input  logic [IW-1:0] h_addr,
   input  logic [DW-1:0] h_wdata,
   output logic [DW-1:0] h_rdata,
   input  logic [IW-1:0] s_raddr,
   output logic [DW-1:0] s_rdata,
   input  logic          s_we,
   input  logic [IW-1:0] s_waddr,
   input  logic [DW-1:0] s_wdata
);
   logic [DW-1:0] ent [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          q <= '0;
         else if (s_we && s_waddr == IW'(g))  q <= s_wdata;
         else if (h_we && h_addr == IW'(g))   q <= h_wdata;
      end
      assign ent[g] = q;
   end

   assign h_rdata = ent[h_addr];
   assign s_rdata = ent[s_raddr];
endmodule

// File: rtl/dma_sock_irq.sv
module dma_sock_irq #(
   parameter int unsigned NB = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mask_we,
   input  logic [NB-1:0] mask_wdata,
   input  logic [NB-1:0] clr,
   input  logic [NB-1:0] set,
   output logic [NB-1:0] mask,
   output logic [NB-1:0] flags,
   output logic          irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask  <= '0;
         flags <= '0;
      end else begin
         if (mask_we) mask <= mask_wdata;
         flags <= (flags & ~clr) | (set & mask);
      end
   end

   assign irq = |flags;
endmodule

// File: rtl/dma_socket_seq.sv
module dma_socket_seq
   import dma_sock_pkg::*;
#(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SOCK_W = 8,
   parameter int unsigned BPC    = 4
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_we,
   input  logic [1:0]                 reg_sel,
   input  logic [31:0]                reg_wdata,
   input  logic                       ev_we,
   input  logic [31:0]                ev_data,
   input  logic                       mem_we,
   input  logic [$clog2(DEPTH)-1:0]   mem_addr,
   input  logic [ADDR_W+SOCK_W+48:0]  mem_wdata,
   output logic [ADDR_W+SOCK_W+48:0]  mem_rdata,
   output logic [2:0]                 sock_state,
   output logic                       sock_producer,
   output logic [15:0]                active_dscr,
   output logic [3:0]                 intr_flags,
   output logic                       irq,
   output logic                       evo_valid,
   output logic [SOCK_W-1:0]          evo_sock,
   output logic [31:0]                evo_data
);
   localparam int unsigned IW      = $clog2(DEPTH);
   localparam int unsigned DW      = ADDR_W + SOCK_W + 49;
   localparam int unsigned NXT_LO  = 0;
   localparam int unsigned PEER_LO = 16;
   localparam int unsigned FULL_B  = PEER_LO + SOCK_W;
   localparam int unsigned CNT_LO  = FULL_B + 1;
   localparam int unsigned SIZE_LO = CNT_LO + 16;
   localparam int unsigned ADDR_LO = SIZE_LO + 16;
   localparam logic [SOCK_W-1:0] NO_PEER = {SOCK_W{1'b1}};
   localparam logic [16:0]       STEP    = 17'(BPC);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0 || DEPTH > 65535)
      $error("DEPTH must be a power of two between 2 and 32768");
   if (BPC < 1 || BPC > 65535) $error("BPC must be in 1..65535");
   if (SOCK_W < 1 || SOCK_W > 16) $error("SOCK_W must be in 1..16");
   if (ADDR_W < 1) $error("ADDR_W must be positive");

   sk_state_e          st;
   logic               role;
   logic [15:0]        ptr_q;
   logic [15:0]        cur_idx;
   logic [ADDR_W-1:0]  cur_addr;
   logic [15:0]        cur_size, cur_cnt, cur_next;
   logic               cur_full;
   logic [SOCK_W-1:0]  cur_peer;

   logic [DW-1:0]      s_rdata, s_wdata;
   logic               s_we, ctl_wr, ld_full, ld_ready, ev_hit;
   logic [IRQ_NB-1:0]  irq_set, irq_clr, irq_mask;
   logic               unused_bits;

   assign ctl_wr   = reg_we && reg_sel == SEL_CTRL;
   assign ld_full  = s_rdata[FULL_B];
   assign ld_ready = role ? !ld_full : ld_full;
   assign ev_hit   = ev_we && ev_data[15:0] == cur_idx && ev_data[16] == !role;
   assign s_we     = st == SK_DONE && !ctl_wr;
   assign s_wdata  = {cur_addr, cur_size, cur_cnt, cur_full, cur_peer, cur_next};
   assign unused_bits = ^{reg_wdata[31:16], ev_data[31:17]};

   dma_sock_dscr_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .h_we(mem_we), .h_addr(mem_addr), .h_wdata(mem_wdata), .h_rdata(mem_rdata),
      .s_raddr(cur_idx[IW-1:0]), .s_rdata(s_rdata),
      .s_we(s_we), .s_waddr(cur_idx[IW-1:0]), .s_wdata(s_wdata)
   );

   always_comb begin
      irq_set = '0;
      if (!ctl_wr) begin
         irq_set[IRQ_PROD]  = st == SK_DONE && role && cur_peer == NO_PEER;
         irq_set[IRQ_CONS]  = st == SK_DONE && !role && cur_peer == NO_PEER;
         irq_set[IRQ_STALL] = st == SK_LOAD && !ld_ready;
         irq_set[IRQ_SUSP]  = st == SK_DONE && cur_next == CHAIN_END;
      end else begin
         irq_set[IRQ_SUSP]  = reg_wdata[0] && ptr_q == CHAIN_END;
      end
      irq_clr = (reg_we && reg_sel == SEL_INTR) ? reg_wdata[IRQ_NB-1:0] : '0;
   end

   dma_sock_irq #(.NB(IRQ_NB)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .mask_we(reg_we && reg_sel == SEL_MASK), .mask_wdata(reg_wdata[IRQ_NB-1:0]),
      .clr(irq_clr), .set(irq_set), .mask(irq_mask), .flags(intr_flags), .irq(irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SK_OFF;
         role      <= 1'b0;
         ptr_q     <= CHAIN_END;
         cur_idx   <= CHAIN_END;
         cur_addr  <= '0;
         cur_size  <= '0;
         cur_cnt   <= '0;
         cur_full  <= 1'b0;
         cur_peer  <= '0;
         cur_next  <= '0;
         evo_valid <= 1'b0;
         evo_sock  <= '0;
         evo_data  <= '0;
      end else begin
         evo_valid <= 1'b0;
         if (reg_we && reg_sel == SEL_PTR) ptr_q <= reg_wdata[15:0];
         if (ctl_wr) begin
            role <= reg_wdata[1];
            if (reg_wdata[0]) begin
               cur_idx <= ptr_q;
               st      <= (ptr_q == CHAIN_END) ? SK_SUSP : SK_LOAD;
            end else begin
               cur_idx <= CHAIN_END;
               st      <= SK_OFF;
            end
         end else begin
            unique case (st)
               SK_LOAD: begin
                  cur_addr <= s_rdata[ADDR_LO +: ADDR_W];
                  cur_size <= s_rdata[SIZE_LO +: 16];
                  cur_cnt  <= (role && ld_ready) ? 16'd0 : s_rdata[CNT_LO +: 16];
                  cur_full <= ld_full;
                  cur_peer <= s_rdata[PEER_LO +: SOCK_W];
                  cur_next <= s_rdata[NXT_LO +: 16];
                  st       <= ld_ready ? SK_RUN : SK_STALL;
               end
               SK_RUN: begin
                  if (role) begin
                     if ({1'b0, cur_cnt} + STEP >= {1'b0, cur_size}) begin
                        cur_cnt  <= cur_size;
                        cur_full <= 1'b1;
                        st       <= SK_DONE;
                     end else begin
                        cur_cnt <= cur_cnt + STEP[15:0];
                     end
                  end else begin
                     if ({1'b0, cur_cnt} <= STEP) begin
                        cur_cnt  <= '0;
                        cur_full <= 1'b0;
                        st       <= SK_DONE;
                     end else begin
                        cur_cnt <= cur_cnt - STEP[15:0];
                     end
                  end
               end
               SK_STALL: begin
                  if (ev_hit) begin
                     cur_full <= !role;
                     cur_cnt  <= role ? 16'd0 : cur_size;
                     st       <= SK_RUN;
                  end
               end
               SK_DONE: begin
                  if (cur_peer != NO_PEER) begin
                     evo_valid <= 1'b1;
                     evo_sock  <= cur_peer;
                     evo_data  <= {15'd0, role, cur_idx};
                  end
                  if (cur_next == CHAIN_END) begin
                     cur_idx <= CHAIN_END;
                     st      <= SK_SUSP;
                  end else begin
                     cur_idx <= cur_next;
                     st      <= SK_LOAD;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sock_state    = st;
   assign sock_producer = role;
   assign active_dscr   = cur_idx;
endmodule

// File: rtl/dma_sock_chk.sv
module dma_sock_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [2:0]  st,
   input logic        role,
   input logic [15:0] cur_idx,
   input logic [15:0] cur_cnt,
   input logic [15:0] cur_size,
   input logic        ev_we,
   input logic        evo_valid,
   input logic [3:0]  mask,
   input logic [3:0]  flags
);
   p_idle_no_dscr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 3'd0 || st == 3'd5) |-> cur_idx == 16'hFFFF);

   p_evo_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      evo_valid |=> !evo_valid);

   p_stall_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 3'd2 && $past(st) == 3'd3) |-> $past(ev_we));

   p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 3'd2 && role) |-> cur_cnt <= cur_size);

   p_stall_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 3'd3 && $past(st) == 3'd1 && $past(mask[2])) |-> flags[2]);

   p_done_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      st == 3'd4 |=> st != 3'd4);
endmodule

bind dma_socket_seq dma_sock_chk u_chk (
   .clk(clk), .rst_n(rst_n), .st(st), .role(role), .cur_idx(cur_idx),
   .cur_cnt(cur_cnt), .cur_size(cur_size), .ev_we(ev_we),
   .evo_valid(evo_valid), .mask(irq_mask), .flags(intr_flags)
);

// File: tb/dma_socket_seq_test.sv
module dma_socket_seq_test;
   localparam int CLK_NS = 10;
   localparam int DEPTH = 8, AW = 16, SW = 4, BPC = 4;
   localparam int DW = AW + SW + 49;
   localparam logic [SW-1:0] NONE = {SW{1'b1}};

   logic clk = 0, rst_n = 0;
   logic reg_we = 0, ev_we = 0, mem_we = 0;
   logic [1:0] reg_sel = 0;
   logic [31:0] reg_wdata = 0, ev_data = 0;
   logic [2:0] mem_addr = 0;
   logic [DW-1:0] mem_wdata = 0, mem_rdata;
   logic [2:0] sock_state;
   logic sock_producer, irq, evo_valid;
   logic [15:0] active_dscr;
   logic [3:0] intr_flags;
   logic [SW-1:0] evo_sock;
   logic [31:0] evo_data;
   int n_chk = 0, n_fail = 0;

   always #(CLK_NS/2) clk = ~clk;

   dma_socket_seq #(.DEPTH(DEPTH), .ADDR_W(AW), .SOCK_W(SW), .BPC(BPC)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .ev_we(ev_we), .ev_data(ev_data), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sock_state(sock_state),
      .sock_producer(sock_producer), .active_dscr(active_dscr), .intr_flags(intr_flags),
      .irq(irq), .evo_valid(evo_valid), .evo_sock(evo_sock), .evo_data(evo_data));

   function automatic logic [DW-1:0] mk(input logic [AW-1:0] a, input logic [15:0] sz,
         input logic [15:0] c, input logic f, input logic [SW-1:0] p, input logic [15:0] nx);
      return {a, sz, c, f, p, nx};
   endfunction

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
      reg_we = 1; reg_sel = s; reg_wdata = d;
      @(negedge clk); reg_we = 0;
   endtask

   task automatic wr_mem(input int i, input logic [DW-1:0] w);
      mem_we = 1; mem_addr = 3'(i); mem_wdata = w;
      @(negedge clk); mem_we = 0;
   endtask

   task automatic send_ev(input logic ty, input logic [15:0] idx);
      ev_we = 1; ev_data = {15'd0, ty, idx};
      @(negedge clk); ev_we = 0;
   endtask

   function automatic logic [DW-1:0] rd_mem(input int i);
      return uut.u_mem.ent[i];
   endfunction

   task automatic peek(input int i, output logic [DW-1:0] w);
      mem_addr = 3'(i); #1; w = mem_rdata;
   endtask

   task automatic run_to(input logic [2:0] tgt, output int runs, output int evos,
         output logic [SW-1:0] es, output logic [31:0] ed);
      runs = 0; evos = 0; es = 0; ed = 0;
      for (int k = 0; k < 300; k++) begin
         if (sock_state == 3'd2) runs++;
         if (evo_valid) begin evos++; es = evo_sock; ed = evo_data; end
         if (sock_state == tgt) return;
         @(negedge clk);
      end
      chk("watch state", {125'd0, sock_state}, {125'd0, tgt});
   endtask

   function automatic int steps(input int n);
      return (n == 0) ? 1 : (n + BPC - 1) / BPC;
   endfunction

   initial begin
      #(CLK_NS * 150000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      int runs, evos;
      logic [SW-1:0] es;
      logic [31:0] ed;
      logic [DW-1:0] w;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 state", {125'd0, sock_state}, 0);
      chk("R1 active", {112'd0, active_dscr}, 128'hFFFF);
      chk("R1 intr", {123'd0, irq, intr_flags}, 0);
      chk("R1 evo", {127'd0, evo_valid}, 0);
      rst_n = 1;
      @(negedge clk);
      wr_reg(2'd3, 32'hF);

      // R3 producer sweep over sizes
      for (int s = 0; s <= 12; s++) begin
         wr_mem(2, mk(16'h100 + 16'(s), 16'(s), 16'h7, 1'b0, NONE, 16'hFFFF));
         wr_reg(2'd1, 32'd2);
         wr_reg(2'd2, 32'hF);
         wr_reg(2'd0, 32'h3);
         run_to(3'd5, runs, evos, es, ed);
         chk("R3 run cycles", 128'(runs), 128'(steps(s)));
         peek(2, w);
         chk("R3 writeback", 128'(w), 128'(mk(16'h100 + 16'(s), 16'(s), 16'(s), 1'b1, NONE, 16'hFFFF)));
         chk("R6 produce intr no peer", {123'd0, irq, intr_flags}, 128'h19);
         chk("R6 no event", 128'(evos), 0);
         chk("R9 suspend idle", {112'd0, active_dscr}, 128'hFFFF);
         @(negedge clk);
      end

      // R4 consumer sweep over counts
      for (int c = 0; c <= 12; c++) begin
         wr_mem(5, mk(16'h200, 16'd16, 16'(c), 1'b1, NONE, 16'hFFFF));
         wr_reg(2'd1, 32'd5);
         wr_reg(2'd2, 32'hF);
         wr_reg(2'd0, 32'h1);
         run_to(3'd5, runs, evos, es, ed);
         chk("R4 drain cycles", 128'(runs), 128'(steps(c)));
         peek(5, w);
         chk("R4 writeback", 128'(w), 128'(mk(16'h200, 16'd16, 16'd0, 1'b0, NONE, 16'hFFFF)));
         chk("R6 consume intr", {123'd0, irq, intr_flags}, 128'h1A);
         @(negedge clk);
      end

      // R5 R7 R8 producer chain with peer and stall
      wr_mem(0, mk(16'hA000, 16'd8, 16'd0, 1'b0, 4'd3, 16'd1));
      wr_mem(1, mk(16'hB000, 16'd8, 16'd8, 1'b1, 4'd3, 16'hFFFF));
      wr_reg(2'd1, 32'd0);
      wr_reg(2'd2, 32'hF);
      wr_reg(2'd0, 32'h3);
      run_to(3'd3, runs, evos, es, ed);
      chk("R5 one event", 128'(evos), 1);
      chk("R5 event sock", 128'(es), 3);
      chk("R5 event word", 128'(ed), 128'h10000);
      chk("R7 stall active", {112'd0, active_dscr}, 1);
      chk("R7 stall intr only", {124'd0, intr_flags}, 4'b0100);
      send_ev(1'b0, 16'd0);
      chk("R8 wrong index ignored", {125'd0, sock_state}, 3);
      send_ev(1'b1, 16'd1);
      chk("R8 wrong type ignored", {125'd0, sock_state}, 3);
      send_ev(1'b0, 16'd1);
      run_to(3'd5, runs, evos, es, ed);
      chk("R8 resumed fill cycles", 128'(runs), 2);
      chk("R5 second event", {95'd0, es, ed}, {95'd0, 4'd3, 32'h10001});
      peek(1, w);
      chk("R8 writeback", 128'(w), 128'(mk(16'hB000, 16'd8, 16'd8, 1'b1, 4'd3, 16'hFFFF)));

      // R8 consumer enabled on empty buffer
      wr_mem(4, mk(16'hC000, 16'd6, 16'd0, 1'b0, 4'd2, 16'hFFFF));
      wr_reg(2'd1, 32'd4);
      wr_reg(2'd2, 32'hF);
      wr_reg(2'd0, 32'h1);
      run_to(3'd3, runs, evos, es, ed);
      chk("R7 consumer stall intr", {124'd0, intr_flags}, 4'b0100);
      send_ev(1'b0, 16'd4);
      chk("R8 consumer wrong type", {125'd0, sock_state}, 3);
      send_ev(1'b1, 16'd4);
      run_to(3'd5, runs, evos, es, ed);
      chk("R8 consumer drain", 128'(runs), 2);
      chk("R5 consume event", {95'd0, es, ed}, {95'd0, 4'd2, 32'h4});
      peek(4, w);
      chk("R4 consumer writeback", 128'(w), 128'(mk(16'hC000, 16'd6, 16'd0, 1'b0, 4'd2, 16'hFFFF)));

      // R6 masked interrupts
      wr_reg(2'd3, 32'h0);
      wr_reg(2'd2, 32'hF);
      wr_mem(2, mk(16'h1, 16'd4, 16'd0, 1'b0, NONE, 16'hFFFF));
      wr_reg(2'd1, 32'd2);
      wr_reg(2'd0, 32'h3);
      run_to(3'd5, runs, evos, es, ed);
      chk("R6 mask off no intr", {123'd0, irq, intr_flags}, 0);
      wr_reg(2'd3, 32'hF);

      // R10 write-one-to-clear
      wr_mem(2, mk(16'h1, 16'd4, 16'd0, 1'b0, NONE, 16'hFFFF));
      wr_reg(2'd0, 32'h3);
      run_to(3'd5, runs, evos, es, ed);
      chk("R10 set", {123'd0, irq, intr_flags}, 128'h19);
      wr_reg(2'd2, 32'h1);
      chk("R10 clear bit0", {123'd0, irq, intr_flags}, 128'h18);
      wr_reg(2'd2, 32'h8);
      chk("R10 clear all", {123'd0, irq, intr_flags}, 0);

      // R2 null head and disable
      wr_reg(2'd1, 32'hFFFF);
      wr_reg(2'd0, 32'h1);
      chk("R2 null head suspends", {125'd0, sock_state}, 5);
      chk("R9 suspend intr", {124'd0, intr_flags}, 4'b1000);
      chk("R2 role consumer", {127'd0, sock_producer}, 0);
      wr_mem(4, mk(16'h0, 16'd6, 16'd0, 1'b0, NONE, 16'hFFFF));
      wr_reg(2'd1, 32'd4);
      wr_reg(2'd0, 32'h1);
      run_to(3'd3, runs, evos, es, ed);
      wr_reg(2'd0, 32'h0);
      chk("R2 disable", {109'd0, sock_state, active_dscr}, {109'd0, 3'd0, 16'hFFFF});

      // R11 host port layout
      wr_mem(7, mk(16'h1234, 16'h0056, 16'h0078, 1'b1, 4'h9, 16'h0006));
      peek(7, w);
      chk("R11 readback", 128'(w), 128'({16'h1234, 16'h0056, 16'h0078, 1'b1, 4'h9, 16'h0006}));

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   logic unused_tb;
   assign unused_tb = ^rd_mem(0);
endmodule